// File: doc/BRIEF.md
# Nesting-Counter Interrupt Controller

This block collects ten peripheral request lines and presents one interrupt, with the index of its source, to a processor core. Each request is held in a per-source pending flag. The flag stays set until the core acknowledges that source. A software-writable mask selects which pending sources may be delivered.

A single enable flag would normally gate delivery. Here a 4-bit nesting counter does that job instead, and delivery is allowed only while the counter reads zero. A write of any value to the "block" address raises the counter by one. A write to the "unblock" address lowers it by one, but never below zero. Each interrupt the core accepts raises the counter automatically, so a handler must write the unblock address as its last action.

Changes to the mask and to the counter take effect on delivery through a fixed pipeline of `LAT` cycles, where `LAT` is between 1 and 6. The pipeline models the settling delay of the processor.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the mask and the counter read 0, no source is pending, and `irq_o` is low.
- R2: A request pulse of one cycle on `src_req[i]` sets a pending flag. The flag stays set after the request falls, until source i is accepted.
- R3: A pending source whose mask bit is 0 is not delivered. Mask bit i enables source i. The sources on bits 0 to 9 are, in order: DAC, SCI, SDI, ADC, UART transmit, UART receive, timer 0, timer 1, resampler and sidestream modulator.
- R4: When several enabled sources are pending, `irq_idx` names the highest-numbered one.
- R5: A write to address 1 (block) adds one to the counter whatever the data. A write to address 2 (unblock) subtracts one. An unblock write while the counter is 0 leaves it at 0.
- R6: While the delayed counter value is nonzero, `irq_o` stays low for every source.
- R7: The core accepts an interrupt by asserting `irq_ack` while `irq_o` is high. Acceptance adds one to the counter and clears the pending flag of the source named by `irq_idx`. When `irq_o` is low, `irq_ack` is ignored.
- R8: A raise of the counter at 15 leaves it at 15. It never wraps to 0.
- R9: If an acceptance and a counter write fall in the same cycle, the counter changes by the sum of both effects.
- R10: A change of the mask or of the counter made at clock edge E shows on `irq_o` exactly `LAT` edges after E. `LAT` defaults to 6.
- R11: Address 0 reads the mask in bits 9:0. Address 3 reads the counter in bits 3:0. Addresses 1 and 2 read as 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 10 | Peripheral request lines, sampled each edge |
| reg_sel | input | 2 | Register address: 0 mask, 1 block, 2 unblock, 3 counter |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 10 | Write data (used only by the mask) |
| reg_rdata | output | 16 | Read data of the addressed register, combinational |
| irq_o | output | 1 | Interrupt request to the core |
| irq_idx | output | 4 | Index of the source being delivered |
| irq_ack | input | 1 | Acceptance from the core |

## Verification
The hardest case to reach is the window after an acceptance. There the counter has already risen, but the delayed view still reads zero, so `irq_o` stays high and shows the next-lower pending source for `LAT` more cycles. The stimulus makes two sources pending and accepts the higher one. It then samples `irq_o` at the cycle just before and the cycle just after the delay ends. In a separate step it drives an acceptance and an unblock write in the same cycle, to show that the two counter changes cancel.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC = 10,
  parameter int CW   = 4,
  parameter int DW   = 16,
  parameter int LAT  = 6,
  localparam int IW  = $clog2(NSRC),
  localparam int CMAX = (1 << CW) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_o,
  output logic [IW-1:0]   irq_idx,
  input  logic            irq_ack
);

  logic [NSRC-1:0] mask, pend, live, clr;
  logic [CW-1:0]   cnt, cnt_nxt;
  logic [NSRC-1:0] mpipe [LAT];
  logic [LAT-1:0]  zpipe;
  logic            wr_mask, wr_blk, wr_unb, acc;

  assign wr_mask = reg_wr && reg_sel == 2'd0;
  assign wr_blk  = reg_wr && reg_sel == 2'd1;
  assign wr_unb  = reg_wr && reg_sel == 2'd2;
  assign acc     = irq_ack && irq_o;
  assign clr     = acc ? (NSRC'(1) << irq_idx) : '0;

  always_comb begin
    int t;
    t = int'(cnt) + int'(wr_blk) + int'(acc) - int'(wr_unb);
    if (t < 0) t = 0;
    if (t > CMAX) t = CMAX;
    cnt_nxt = CW'(t);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mask <= '0;
      pend <= '0;
      cnt  <= '0;
    end else begin
      if (wr_mask) mask <= reg_wdata;
      pend <= (pend & ~clr) | src_req;
      cnt  <= cnt_nxt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      zpipe <= '1;
      for (int i = 0; i < LAT; i++) mpipe[i] <= '0;
    end else begin
      mpipe[0] <= mask;
      zpipe[0] <= (cnt == '0);
      for (int i = 1; i < LAT; i++) begin
        mpipe[i] <= mpipe[i-1];
        zpipe[i] <= zpipe[i-1];
      end
    end

  assign live  = pend & mpipe[LAT-1];
  assign irq_o = zpipe[LAT-1] && (|live);

  always_comb begin
    irq_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (live[i]) irq_idx = IW'(i);
  end

  always_comb
    case (reg_sel)
      2'd0:    reg_rdata = DW'(mask);
      2'd3:    reg_rdata = DW'(cnt);
      default: reg_rdata = '0;
    endcase

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk #(
  parameter int NSRC = 10,
  parameter int CW   = 4,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      reg_sel,
  input logic            reg_wr,
  input logic            irq_ack,
  input logic            irq_o,
  input logic [IW-1:0]   irq_idx,
  input logic [CW-1:0]   cnt,
  input logic [NSRC-1:0] pend
);
  logic blk, unb, acc;
  assign blk = reg_wr && reg_sel == 2'd1;
  assign unb = reg_wr && reg_sel == 2'd2;
  assign acc = irq_ack && irq_o;

  a_r2_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (pend & $past(pend)) == $past(pend));

  a_r5_block_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && !acc && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (unb && !acc && cnt == '0) |=> cnt == '0);

  a_r7_ack_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !blk && !unb && cnt != '1) |=> cnt == $past(cnt) + 1'b1);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && !unb) |=> cnt == '1);

  a_r4_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend[irq_idx]);
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(.NSRC(NSRC), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .irq_ack(irq_ack), .irq_o(irq_o), .irq_idx(irq_idx), .cnt(cnt), .pend(pend)
);

// File: tb/nest_irq_ctrl_tb.sv
module nest_irq_ctrl_tb;
  localparam int LAT = 6;
  logic clk = 0, rst_n = 0;
  logic [9:0] src_req = '0, reg_wdata = '0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 0, irq_ack = 0;
  logic [15:0] reg_rdata;
  logic irq_o;
  logic [3:0] irq_idx;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  nest_irq_ctrl #(.LAT(LAT)) u_dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [9:0] d, logic ack = 0);
    reg_sel = a; reg_wdata = d; reg_wr = 1; irq_ack = ack;
    @(negedge clk);
    reg_wr = 0; irq_ack = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_sel = a; #1 v = reg_rdata;
  endtask

  task automatic pulse(logic [9:0] r);
    src_req = r; @(negedge clk); src_req = '0;
  endtask

  task automatic ack();
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic t_reset();
    int v;
    chk("R1 irq", irq_o, 0);
    rd(0, v); chk("R1 mask", v, 0);
    rd(3, v); chk("R1 cnt", v, 0);
  endtask

  task automatic t_mask_latency();
    int v;
    pulse(10'h008);
    step(1); chk("R3 masked", irq_o, 0);
    chk("R2 held", irq_o, 0);
    wr(0, 10'h088);
    rd(0, v); chk("R11 mask read", v, 'h088);
    step(LAT-1); chk("R10 mask before", irq_o, 0);
    step(1); chk("R10 mask after", irq_o, 1);
    chk("R2 pending kept", irq_idx, 3);
  endtask

  task automatic t_priority();
    pulse(10'h080);
    chk("R4 highest", irq_idx, 7);
    chk("R4 irq", irq_o, 1);
  endtask

  task automatic t_accept();
    int v;
    ack();
    rd(3, v); chk("R7 cnt inc", v, 1);
    chk("R7 cleared 7", irq_idx, 3);
    step(LAT-1); chk("R10 cnt before", irq_o, 1);
    step(1); chk("R6 blocked", irq_o, 0);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    rd(3, v); chk("R7 ack ignored", v, 1);
    wr(2, 10'h000);
    rd(3, v); chk("R5 unblock", v, 0);
    step(LAT); chk("R10 unblocked", irq_o, 1);
    chk("R10 idx", irq_idx, 3);
    wr(2, 10'h000, 1);
    rd(3, v); chk("R9 net zero", v, 0);
    chk("R7 cleared 3", irq_o, 0);
  endtask

  task automatic t_counter();
    int v;
    wr(1, 10'h000);
    rd(3, v); chk("R5 block data0", v, 1);
    wr(1, 10'h3FF);
    rd(3, v); chk("R5 block dataX", v, 2);
    wr(3, 10'h000);
    rd(3, v); chk("R11 cnt write ignored", v, 2);
    rd(1, v); chk("R11 wo addr", v, 0);
    for (int i = 0; i < 20; i++) wr(1, 10'h000);
    rd(3, v); chk("R8 saturate", v, 15);
    for (int i = 0; i < 16; i++) wr(2, 10'h000);
    rd(3, v); chk("R5 floor", v, 0);
  endtask

  task automatic t_block();
    int v;
    wr(0, 10'h3FF);
    wr(1, 10'h000);
    step(LAT+1);
    pulse(10'h020);
    step(2); chk("R6 nonzero blocks", irq_o, 0);
    wr(2, 10'h000);
    step(LAT-1); chk("R10 unblock before", irq_o, 0);
    step(1); chk("R6 delivered", irq_o, 1);
    chk("R4 idx5", irq_idx, 5);
    rd(3, v); chk("R5 cnt0", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(1);
    t_reset();
    t_mask_latency();
    t_priority();
    t_accept();
    t_counter();
    t_block();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule